// File: doc/BRIEF.md
# Register Rename Unit with Free Pool

This unit gives a fresh physical register to every instruction that writes a register. It accepts at most one instruction per cycle. Each instruction names two source registers and, optionally, one destination register, all as architectural numbers. Each source number is looked up in a map table and comes back as the physical tag that holds its newest value. If the instruction has a destination, the unit takes a tag from the head of a first-in first-out pool of free physical registers. It reports that tag together with the tag the destination mapped to before, and it points the map entry at the new tag.

Because every write lands in a register no earlier instruction used, write-after-read and write-after-write conflicts between architectural names disappear. A read still sees the most recent earlier write, so true dependences are kept. The tag that was mapped before is handed out so that commit logic can return it through the release port. Commit logic returns it once the value in that register has been superseded and nothing still reads it.

When the pool is empty and the instruction carries a destination, the unit raises stall. In that cycle it leaves the map and the pool unchanged, and the instruction has to be presented again. The outputs are combinational from the current state. All state changes at the rising clock edge.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i looks up physical tag i for every i in 0..ARCH_REGS-1, and stall is low.
- R2: After reset the pool holds tags ARCH_REGS..PHYS_REGS-1, which with the defaults is 8 through 15. Successive accepted destinations receive them in ascending order.
- R3: A source lookup uses the map as it stood before this instruction's own destination update. An instruction that reads and writes the same register gets the old tag for the source.
- R4: After an instruction's destination is accepted, later instructions that read that architectural register get the new physical tag.
- R5: dst_prev_phys gives the tag the destination register mapped to just before the instruction was accepted.
- R6: If in_valid and dst_valid are high and the pool is empty, stall is high, and the map and the pool remain unchanged.
- R7: An instruction with dst_valid low never stalls, takes nothing from the pool and changes no mapping.
- R8: Tags returned with rel_valid/rel_phys join the tail of the pool and are handed out only after every tag already in the pool.
- R9: A release and an allocation in the same cycle while the pool is empty leave the allocation stalled. On the next cycle the same instruction receives the released tag.
- R10: With in_valid low, no mapping changes and nothing is taken from the pool, whatever the other request inputs hold, and stall stays low.
- R11: An accepted destination's new tag differs from its previous tag. Renaming a register a second time yields a tag different from the first rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| src0_arch | input | $clog2(ARCH_REGS) | First source architectural number |
| src1_arch | input | $clog2(ARCH_REGS) | Second source architectural number |
| dst_valid | input | 1 | The instruction writes a destination |
| dst_arch | input | $clog2(ARCH_REGS) | Destination architectural number |
| rel_valid | input | 1 | Return one physical tag to the pool |
| rel_phys | input | $clog2(PHYS_REGS) | Tag being returned |
| stall | output | 1 | Instruction not accepted: pool empty |
| src0_phys | output | $clog2(PHYS_REGS) | Physical tag for the first source |
| src1_phys | output | $clog2(PHYS_REGS) | Physical tag for the second source |
| dst_phys | output | $clog2(PHYS_REGS) | New tag for the destination (valid when accepted) |
| dst_prev_phys | output | $clog2(PHYS_REGS) | Tag the destination mapped to before this instruction |

## Verification
The hardest situation to reach is a release that arrives in the very cycle an instruction meets an empty pool. That needs the whole pool used up first, and it needs a tag that is known to be superseded. The bench therefore renames destinations until all eight spare tags are gone, checking the order they come out in. It then returns a tag that an earlier rename displaced, in the same cycle as a new destination request. Finally it repeats that request on the next cycle. A second pass returns two tags in turn and checks that they come back in arrival order.

// File: rtl/rr_pkg.sv
package rr_pkg;

   typedef enum logic [1:0] {
      FL_IDLE = 2'b00,
      FL_POP  = 2'b01,
      FL_PUSH = 2'b10,
      FL_BOTH = 2'b11
   } fl_op_e;

   function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
      return (ptr == depth - 1) ? 0 : ptr + 1;
   endfunction

endpackage

// File: rtl/rr_map_table.sv
module rr_map_table #(
   parameter int ARCH_REGS = 8,
   parameter int PHYS_REGS = 16,
   parameter int N_RD      = 2,
   localparam int AW = $clog2(ARCH_REGS),
   localparam int PW = $clog2(PHYS_REGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_RD*AW-1:0]   rd_arch,
   output logic [N_RD*PW-1:0]   rd_phys,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_arch,
   input  logic [PW-1:0]        wr_phys,
   output logic [PW-1:0]        old_phys,
   output logic [ARCH_REGS*PW-1:0] map_flat
);

   logic [PW-1:0] entry_q [ARCH_REGS];

   for (genvar i = 0; i < ARCH_REGS; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            entry_q[i] <= PW'(i);
         else if (wr_en && (int'(wr_arch) == i))
            entry_q[i] <= wr_phys;
      end
      assign map_flat[i*PW +: PW] = entry_q[i];
   end

   for (genvar p = 0; p < N_RD; p++) begin : g_rd
      assign rd_phys[p*PW +: PW] = entry_q[rd_arch[p*AW +: AW]];
   end

   assign old_phys = entry_q[wr_arch];

endmodule

// File: rtl/rr_free_fifo.sv
module rr_free_fifo #(
   parameter int ARCH_REGS = 8,
   parameter int PHYS_REGS = 16,
   localparam int DEPTH = PHYS_REGS - ARCH_REGS,
   localparam int PW    = $clog2(PHYS_REGS),
   localparam int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNTW  = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pop,
   input  logic            push,
   input  logic [PW-1:0]   push_tag,
   output logic [PW-1:0]   head_tag,
   output logic            empty,
   output logic [CNTW-1:0] count
);
   import rr_pkg::*;

   logic [PW-1:0]   slot_q [DEPTH];
   logic [PTRW-1:0] head_q, tail_q;
   logic [CNTW-1:0] count_q;
   fl_op_e          op;

   assign op = fl_op_e'({push, pop});

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[k] <= PW'(ARCH_REGS + k);
         else if (push && (int'(tail_q) == k))
            slot_q[k] <= push_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= CNTW'(DEPTH);
      end else begin
         if (pop)
            head_q <= PTRW'(ring_next(int'(head_q), DEPTH));
         if (push)
            tail_q <= PTRW'(ring_next(int'(tail_q), DEPTH));
         case (op)
            FL_POP:  count_q <= count_q - 1'b1;
            FL_PUSH: count_q <= count_q + 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign head_tag = slot_q[head_q];
   assign empty    = (count_q == '0);
   assign count    = count_q;

endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
   parameter int ARCH_REGS = 8,
   parameter int PHYS_REGS = 16,
   localparam int AW   = $clog2(ARCH_REGS),
   localparam int PW   = $clog2(PHYS_REGS),
   localparam int CNTW = $clog2(PHYS_REGS - ARCH_REGS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [AW-1:0] src0_arch,
   input  logic [AW-1:0] src1_arch,
   input  logic          dst_valid,
   input  logic [AW-1:0] dst_arch,
   input  logic          rel_valid,
   input  logic [PW-1:0] rel_phys,
   output logic          stall,
   output logic [PW-1:0] src0_phys,
   output logic [PW-1:0] src1_phys,
   output logic [PW-1:0] dst_phys,
   output logic [PW-1:0] dst_prev_phys
);

   if (ARCH_REGS < 2) begin : g_bad_arch
      $error("reg_rename: ARCH_REGS must be at least 2");
   end
   if (PHYS_REGS < ARCH_REGS + 2) begin : g_bad_phys
      $error("reg_rename: PHYS_REGS must exceed ARCH_REGS by at least 2");
   end

   logic            fl_empty;
   logic            alloc;
   logic [PW-1:0]   head_tag;
   logic [CNTW-1:0] fl_count;
   logic [2*PW-1:0] rd_phys;
   logic [ARCH_REGS*PW-1:0] map_flat;

   assign stall = in_valid & dst_valid & fl_empty;
   assign alloc = in_valid & dst_valid & ~fl_empty;

   rr_map_table #(
      .ARCH_REGS (ARCH_REGS),
      .PHYS_REGS (PHYS_REGS),
      .N_RD      (2)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_arch  ({src1_arch, src0_arch}),
      .rd_phys  (rd_phys),
      .wr_en    (alloc),
      .wr_arch  (dst_arch),
      .wr_phys  (head_tag),
      .old_phys (dst_prev_phys),
      .map_flat (map_flat)
   );

   rr_free_fifo #(
      .ARCH_REGS (ARCH_REGS),
      .PHYS_REGS (PHYS_REGS)
   ) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (alloc),
      .push     (rel_valid),
      .push_tag (rel_phys),
      .head_tag (head_tag),
      .empty    (fl_empty),
      .count    (fl_count)
   );

   assign src0_phys = rd_phys[0 +: PW];
   assign src1_phys = rd_phys[PW +: PW];
   assign dst_phys  = head_tag;

endmodule

// File: rtl/rr_rename_chk.sv
module rr_rename_chk #(
   parameter int ARCH_REGS = 8,
   parameter int PHYS_REGS = 16,
   localparam int AW    = $clog2(ARCH_REGS),
   localparam int PW    = $clog2(PHYS_REGS),
   localparam int DEPTH = PHYS_REGS - ARCH_REGS,
   localparam int CNTW  = $clog2(DEPTH + 1)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    dst_valid,
   input logic [AW-1:0]           dst_arch,
   input logic                    stall,
   input logic                    alloc,
   input logic [PW-1:0]           dst_phys,
   input logic [PW-1:0]           dst_prev_phys,
   input logic                    rel_valid,
   input logic [CNTW-1:0]         fl_count,
   input logic [ARCH_REGS*PW-1:0] map_flat
);

   logic          last_wr;
   logic [AW-1:0] last_arch;
   logic [PW-1:0] last_phys;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_wr   <= 1'b0;
         last_arch <= '0;
         last_phys <= '0;
      end else begin
         last_wr   <= alloc;
         last_arch <= dst_arch;
         last_phys <= dst_phys;
      end
   end

   AST_STALL_NEEDS_DST: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (in_valid && dst_valid));                               // R7
   AST_STALL_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (fl_count == '0));                                      // R6
   AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc |=> (map_flat == $past(map_flat)));                        // R10
   AST_FRESH_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (dst_phys != dst_prev_phys));                           // R11
   AST_MAP_UPDATED: assert property (@(posedge clk) disable iff (!rst_n)
      last_wr |-> (map_flat[int'(last_arch)*PW +: PW] == last_phys));   // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> ((int'(fl_count) < DEPTH) || alloc));               // R8
   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fl_count) <= DEPTH);                                         // R2

endmodule

bind reg_rename rr_rename_chk #(
   .ARCH_REGS (ARCH_REGS),
   .PHYS_REGS (PHYS_REGS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .dst_valid     (dst_valid),
   .dst_arch      (dst_arch),
   .stall         (stall),
   .alloc         (alloc),
   .dst_phys      (dst_phys),
   .dst_prev_phys (dst_prev_phys),
   .rel_valid     (rel_valid),
   .fl_count      (fl_count),
   .map_flat      (map_flat)
);

// File: tb/reg_rename_tb.sv
module reg_rename_tb;
   localparam int ARCH = 8;
   localparam int PHYS = 16;
   localparam int AW   = $clog2(ARCH);
   localparam int PW   = $clog2(PHYS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [AW-1:0] src0_arch = '0, src1_arch = '0, dst_arch = '0;
   logic          dst_valid = 1'b0;
   logic          rel_valid = 1'b0;
   logic [PW-1:0] rel_phys = '0;
   logic          stall;
   logic [PW-1:0] src0_phys, src1_phys, dst_phys, dst_prev_phys;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int exp_map [ARCH];
   int pool [$];

   always #4 clk = ~clk;

   reg_rename #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) u_dut (
      .clk, .rst_n, .in_valid, .src0_arch, .src1_arch, .dst_valid, .dst_arch,
      .rel_valid, .rel_phys, .stall, .src0_phys, .src1_phys, .dst_phys, .dst_prev_phys
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, check combinational outputs, commit at the rising edge.
   task automatic step(input bit iv, input int s0, input int s1, input bit dv, input int d,
                       input bit rv, input int rp, input string tag);
      bit exp_stall;
      @(negedge clk);
      in_valid  = iv;
      src0_arch = AW'(s0);
      src1_arch = AW'(s1);
      dst_valid = dv;
      dst_arch  = AW'(d);
      rel_valid = rv;
      rel_phys  = PW'(rp);
      #1;
      exp_stall = iv && dv && (pool.size() == 0);
      chk({tag, " stall"}, int'(stall), int'(exp_stall));
      if (iv) begin
         chk({tag, " src0"}, int'(src0_phys), exp_map[s0]);
         chk({tag, " src1"}, int'(src1_phys), exp_map[s1]);
      end
      if (iv && dv && !exp_stall) begin
         chk({tag, " dst"},  int'(dst_phys), pool[0]);
         chk({tag, " prev"}, int'(dst_prev_phys), exp_map[d]);
         exp_map[d] = pool.pop_front();
      end
      if (rv) pool.push_back(rp);
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      in_valid = 1'b0; dst_valid = 1'b0; rel_valid = 1'b0;
   endtask

   task automatic t_reset();
      for (int i = 0; i < ARCH; i++)
         step(1, i, ARCH - 1 - i, 0, 0, 0, 0, "R1 identity map / R7 no dst");
   endtask

   task automatic t_sequence();
      // r3 := r3*r5 ; r4 := r3+1 ; r3 := r5+1
      step(1, 3, 5, 1, 3, 0, 0, "R3 R5 R2 first rename");
      chk("R3 src reads old tag", int'(src0_phys), 3);
      chk("R2 first pool tag", int'(dst_phys), 8);
      step(1, 3, 3, 1, 4, 0, 0, "R4 RAW kept");
      chk("R4 reads new tag", int'(src0_phys), 8);
      step(1, 5, 5, 1, 3, 0, 0, "R11 WAW removed");
      chk("R11 second rename tag", int'(dst_phys), 10);
      chk("R5 prev of r3", int'(dst_prev_phys), 8);
      step(1, 0, 1, 1, 0, 0, 0, "R2 order");
      step(1, 0, 1, 1, 1, 0, 0, "R2 order");
      step(1, 0, 1, 1, 2, 0, 0, "R2 order");
      step(1, 0, 1, 1, 6, 0, 0, "R2 order");
      step(1, 6, 1, 1, 7, 0, 0, "R2 last tag");
      chk("R2 last pool tag", int'(dst_phys), 15);
   endtask

   task automatic t_empty_stall();
      step(1, 2, 3, 1, 2, 0, 0, "R6 stall when empty");
      chk("R6 stall high", int'(stall), 1);
      step(1, 2, 3, 0, 0, 0, 0, "R6 map unchanged / R7 no stall");
   endtask

   task automatic t_idle();
      step(0, 1, 1, 1, 1, 0, 0, "R10 invalid ignored");
      step(1, 1, 4, 0, 0, 0, 0, "R10 map unchanged");
      chk("R10 r1 still 12", int'(src0_phys), 12);
   endtask

   task automatic t_release_collide();
      step(1, 4, 4, 1, 4, 1, 3, "R9 same-cycle release stalls");
      chk("R9 stall", int'(stall), 1);
      step(1, 4, 4, 1, 4, 0, 0, "R9 next cycle gets tag");
      chk("R9 released tag", int'(dst_phys), 3);
   endtask

   task automatic t_fifo_order();
      step(0, 0, 0, 0, 0, 1, 8, "R8 release a");
      step(0, 0, 0, 0, 0, 1, 4, "R8 release b");
      step(1, 0, 0, 1, 0, 0, 0, "R8 first out");
      chk("R8 first returned", int'(dst_phys), 8);
      step(1, 1, 0, 1, 1, 1, 11, "R8 second out with push");
      chk("R8 second returned", int'(dst_phys), 4);
      step(1, 0, 1, 1, 5, 0, 0, "R8 tail tag");
      chk("R8 tag pushed last", int'(dst_phys), 11);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=not finished expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < ARCH; i++) exp_map[i] = i;
      for (int k = ARCH; k < PHYS; k++) pool.push_back(k);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 stall low after reset", int'(stall), 0);
      t_reset();
      t_sequence();
      t_empty_stall();
      t_idle();
      t_release_collide();
      t_fifo_order();
      idle_cycle();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule